// File: doc/BRIEF.md
# UART FIFO Controller with Trigger Flags

This block manages the two data queues of one UART channel: a 64-entry receive queue and a 64-entry transmit queue. The serial side pushes received characters and pops characters to send. The host side does the reverse. A single write-only control byte sets how the queues behave. It turns both queues on or off together, empties either queue on its own, picks a receive fill threshold and a transmit free-space threshold from fixed non-linear tables, and chooses the DMA signalling mode.

The block has two threshold flags. The receive flag is raised while the receive queue holds at least the chosen number of characters. The transmit flag is raised while the transmit queue has at least the chosen number of free slots. Software can only change the transmit threshold while the enhanced-function enable input is high. When the queues are turned off, each direction falls back to a one-character holding register, and both thresholds become one.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both counts are 0, the queues are disabled, the DMA mode output is 0, and both threshold selections are code 00. As a result, rx_trig is 0 and tx_trig is 1.
- R2: Control bits 7:6 select the receive threshold: 00 selects 8 characters, 01 selects 16, 10 selects 56 and 11 selects 60. While the queues are enabled, rx_trig is 1 exactly when rx_count is at or above this threshold.
- R3: Control bits 5:4 select the transmit threshold in free slots: 00 selects 8, 01 selects 16, 10 selects 32 and 11 selects 56. While the queues are enabled, tx_trig is 1 exactly when 64 minus tx_count is at or above this threshold.
- R4: A control write updates bits 5:4 only if ext_en is high during that write. Otherwise the previous transmit threshold stays in force.
- R5: Control bit 3 is registered on each write and appears on dma_mode from the next cycle.
- R6: A write with bit 2 set empties the transmit queue in that cycle. A tx push or pop in the same cycle is dropped, and the receive queue is not affected.
- R7: A write with bit 1 set empties the receive queue in that cycle. An rx push or pop in the same cycle is dropped, and the transmit queue is not affected.
- R8: Bit 0 enables both queues. While it is 0, each queue holds at most one character, and both thresholds are 1.
- R9: A write that changes bit 0 empties both queues and drops any push or pop in that cycle.
- R10: Each queue returns characters in the order they were pushed, with the oldest character shown on its read-data port. A push into a full queue is ignored, and so is a pop from an empty queue. A push and a pop in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| ext_en | input | 1 | Enhanced-function enable; gates writes to bits 5:4 |
| rx_push | input | 1 | Push a received character |
| rx_wdata | input | 8 | Received character |
| rx_pop | input | 1 | Pop the oldest received character |
| rx_rdata | output | 8 | Oldest received character |
| rx_count | output | 7 | Receive queue occupancy |
| tx_push | input | 1 | Push a character to send |
| tx_wdata | input | 8 | Character to send |
| tx_pop | input | 1 | Pop the oldest character to send |
| tx_rdata | output | 8 | Oldest character to send |
| tx_count | output | 7 | Transmit queue occupancy |
| rx_trig | output | 1 | Receive fill threshold reached |
| tx_trig | output | 1 | Transmit free-space threshold reached |
| dma_mode | output | 1 | Selected DMA signalling mode |

## Verification
A control write that clears a queue, or that toggles the enable bit, can land in the same cycle as a push or pop on that queue. In that case the clear must win, and the data movement must vanish without a trace. The bench provokes this directly: it clears the receive queue while pushing into it. It also provokes it at random, issuing occasional writes with random clear and enable bits on top of continuous push and pop traffic. A reference queue model judges every cycle. It applies the flush before any push or pop, then compares the counts, the head characters and both flags.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 64,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          ext_en,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_wdata,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_rdata,
  output logic [CW-1:0] rx_count,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_wdata,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_rdata,
  output logic [CW-1:0] tx_count,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          dma_mode
);

  logic          en;
  logic [1:0]    rx_sel, tx_sel;
  logic [W-1:0]  rx_mem [DEPTH];
  logic [W-1:0]  tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] rx_level(input logic [1:0] s);
    case (s)
      2'd0: return CW'(8);
      2'd1: return CW'(16);
      2'd2: return CW'(56);
      default: return CW'(60);
    endcase
  endfunction

  function automatic logic [CW-1:0] tx_level(input logic [1:0] s);
    case (s)
      2'd0: return CW'(8);
      2'd1: return CW'(16);
      2'd2: return CW'(32);
      default: return CW'(56);
    endcase
  endfunction

  wire [CW-1:0] cap      = en ? CW'(DEPTH) : CW'(1);
  wire          en_flip  = cfg_we & (cfg_wdata[0] != en);
  wire          rx_flush = (cfg_we & cfg_wdata[1]) | en_flip;
  wire          tx_flush = (cfg_we & cfg_wdata[2]) | en_flip;
  wire          rx_wr    = rx_push & ~rx_flush & (rx_count < cap);
  wire          rx_rd    = rx_pop  & ~rx_flush & (rx_count != '0);
  wire          tx_wr    = tx_push & ~tx_flush & (tx_count < cap);
  wire          tx_rd    = tx_pop  & ~tx_flush & (tx_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      dma_mode <= 1'b0;
      rx_sel   <= 2'd0;
      tx_sel   <= 2'd0;
    end else if (cfg_we) begin
      en       <= cfg_wdata[0];
      dma_mode <= cfg_wdata[3];
      rx_sel   <= cfg_wdata[7:6];
      if (ext_en) tx_sel <= cfg_wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_count <= '0;
      rx_wp    <= '0;
      rx_rp    <= '0;
    end else if (rx_flush) begin
      rx_count <= '0;
      rx_wp    <= '0;
      rx_rp    <= '0;
    end else begin
      if (rx_wr) rx_wp <= nxt(rx_wp);
      if (rx_rd) rx_rp <= nxt(rx_rp);
      rx_count <= rx_count + CW'(rx_wr) - CW'(rx_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_count <= '0;
      tx_wp    <= '0;
      tx_rp    <= '0;
    end else if (tx_flush) begin
      tx_count <= '0;
      tx_wp    <= '0;
      tx_rp    <= '0;
    end else begin
      if (tx_wr) tx_wp <= nxt(tx_wp);
      if (tx_rd) tx_rp <= nxt(tx_rp);
      tx_count <= tx_count + CW'(tx_wr) - CW'(tx_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
  end

  assign rx_rdata = rx_mem[rx_rp];
  assign tx_rdata = tx_mem[tx_rp];
  assign rx_trig  = rx_count >= (en ? rx_level(rx_sel) : CW'(1));
  assign tx_trig  = (cap - tx_count) >= (en ? tx_level(tx_sel) : CW'(1));

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic          ext_en,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_trig,
  input logic          dma_mode,
  input logic          en,
  input logic [1:0]    tx_sel
);

  assert_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1)));

  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[1] |=> rx_count == '0);

  assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[2] |=> tx_count == '0);

  assert_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> dma_mode == $past(cfg_wdata[3]));

  assert_tx_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !ext_en |=> $stable(tx_sel));

  assert_rx_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> rx_count != '0);

  assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en && rx_count == CW'(1) && rx_push && !rx_pop && !cfg_we |=> rx_count == CW'(1));

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .ext_en(ext_en), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_count(rx_count), .tx_count(tx_count), .rx_trig(rx_trig),
  .dma_mode(dma_mode), .en(en), .tx_sel(tx_sel)
);

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0, ext_en = 0;
  logic [7:0] cfg_wdata = 0;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
  logic [6:0] rx_count, tx_count;
  logic       rx_trig, tx_trig, dma_mode;

  int nchk = 0, nfail = 0;
  bit m_en = 0, m_dma = 0;
  bit [1:0] m_rxs = 0, m_txs = 0;
  byte unsigned rq[$], tq[$];

  always #4 clk = ~clk;

  uart_fifo_ctl u0 (.*);

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rx_thr();
    if (!m_en) return 1;
    case (m_rxs) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
  endfunction

  function automatic int tx_thr();
    if (!m_en) return 1;
    case (m_txs) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
  endfunction

  task automatic model_step();
    int cap = m_en ? 64 : 1;
    bit flip = cfg_we && (cfg_wdata[0] != m_en);
    bit fr = (cfg_we && cfg_wdata[1]) || flip;
    bit ft = (cfg_we && cfg_wdata[2]) || flip;
    if (fr) rq.delete();
    else begin
      bit pu = rx_push && rq.size() < cap;
      if (rx_pop && rq.size() > 0) void'(rq.pop_front());
      if (pu) rq.push_back(rx_wdata);
    end
    if (ft) tq.delete();
    else begin
      bit pu = tx_push && tq.size() < cap;
      if (tx_pop && tq.size() > 0) void'(tq.pop_front());
      if (pu) tq.push_back(tx_wdata);
    end
    if (cfg_we) begin
      m_en = cfg_wdata[0]; m_dma = cfg_wdata[3]; m_rxs = cfg_wdata[7:6];
      if (ext_en) m_txs = cfg_wdata[5:4];
    end
  endtask

  task automatic compare();
    int cap = m_en ? 64 : 1;
    chk("R10 rx_count", rx_count, rq.size());
    chk("R10 tx_count", tx_count, tq.size());
    if (rq.size() > 0) chk("R10 rx_rdata", rx_rdata, rq[0]);
    if (tq.size() > 0) chk("R10 tx_rdata", tx_rdata, tq[0]);
    chk(m_en ? "R2 rx_trig" : "R8 rx_trig", rx_trig, rq.size() >= rx_thr());
    chk(m_en ? "R3 tx_trig" : "R8 tx_trig", tx_trig, (cap - tq.size()) >= tx_thr());
    chk("R5 dma_mode", dma_mode, m_dma);
  endtask

  task automatic cyc(bit we, bit [7:0] d, bit ee, bit rp, bit [7:0] rd, bit ro,
                     bit tp, bit [7:0] td, bit to);
    cfg_we = we; cfg_wdata = d; ext_en = ee;
    rx_push = rp; rx_wdata = rd; rx_pop = ro;
    tx_push = tp; tx_wdata = td; tx_pop = to;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_trig", rx_trig, 0);
    chk("R1 tx_trig", tx_trig, 1);
    chk("R1 dma_mode", dma_mode, 0);

    cyc(1, 8'b00_00_1_0_0_1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 dma set", dma_mode, 1);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 8'(i + 1), 0, 0, 0, 0);
    chk("R2 level 8 reached", rx_trig, 1);

    cyc(1, 8'b11_11_0_0_0_1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 level 60 not reached", rx_trig, 0);
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, 0, 0, 0, 1, 8'(i + 100), 0);
    chk("R4 tx level kept at 8", tx_trig, 1);

    cyc(1, 8'b11_00_0_0_1_1, 0, 1, 8'hAA, 0, 0, 0, 0);
    chk("R7 rx emptied, push dropped", rx_count, 0);
    chk("R7 tx untouched", tx_count, 50);

    cyc(1, 8'b11_11_0_1_0_1, 1, 0, 0, 0, 1, 8'h55, 0);
    chk("R6 tx emptied, push dropped", tx_count, 0);
    chk("R3 free 64 vs 56", tx_trig, 1);
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 0, 1, 8'(i), 0);
    chk("R3 free 55 vs 56", tx_trig, 0);

    cyc(0, 0, 0, 1, 8'h11, 0, 0, 0, 0);
    cyc(1, 8'b00_00_0_0_0_0, 0, 1, 8'h22, 0, 0, 0, 0);
    chk("R9 rx emptied on disable", rx_count, 0);
    chk("R9 tx emptied on disable", tx_count, 0);
    cyc(0, 0, 0, 1, 8'h33, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 8'h44, 0, 0, 0, 0);
    chk("R8 single entry", rx_count, 1);
    chk("R8 first kept", rx_rdata, 8'h33);
    chk("R8 rx threshold 1", rx_trig, 1);

    for (int blk = 0; blk < 16; blk++) begin
      int bias = $urandom_range(20, 80);
      for (int i = 0; i < 400; i++) begin
        bit we = ($urandom_range(0, 63) == 0);
        cyc(we, 8'($urandom), 1'($urandom),
            $urandom_range(0, 99) < bias, 8'($urandom), $urandom_range(0, 99) >= bias,
            $urandom_range(0, 99) < bias, 8'($urandom), $urandom_range(0, 99) >= bias);
      end
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule